// File: doc/BRIEF.md
# Modulo 2^n−1 Parallel-Prefix Adder with Excess-One Correction

This block adds two n-bit residues modulo 2^n − 1 and returns a result that has a single encoding of zero. Each operand is taken to be already reduced, which means it lies in the range 0 to 2^n − 2. The adder works in two parts. A plain binary parallel-prefix adder forms the raw n-bit sum together with the group generate and group propagate terms for every bit. A separate excess-one stage then adds one to that raw sum when the true total is 2^n − 1 or more. Because of this, the all-ones pattern never reaches the output as a second form of zero.

The carry network has two variants, and a parameter picks between them. The log-depth variant has log2(n) combining levels and a dense wiring pattern. The sparse variant sweeps up a tree and then back down, using 2·log2(n) − 1 stages and far fewer cells. Another parameter selects whether the result is captured in an output register, which resets synchronously. With that register enabled the latency is one clock. Typical users are residue-arithmetic datapaths and reverse converters that need a short carry path.

Top module: `mod_mersenne_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the registered `sum` becomes 0, whatever the operands are.
- R2: For reduced operands, `sum` equals (a + b) mod (2^N − 1) one rising edge after the operands are applied, with the output register enabled.
- R3: When a + b = 2^N − 1, `sum` is 0 and not the all-ones pattern.
- R4: When a + b ≥ 2^N, the carry out of the raw sum drives the correction, and `sum` equals a + b − 2^N + 1.
- R5: When a + b < 2^N − 1, no correction is applied and `sum` equals a + b.
- R6: After reset, `sum` never equals the all-ones value 2^N − 1.
- R7: Swapping `a` and `b` gives the same `sum`.
- R8: The log-depth topology (TOPO = TOPO_KS) and the sparse topology (TOPO = TOPO_BK) give identical results for the same operands.
- R9: Adding zero is an identity: b = 0 gives `sum` = a, and a = b = 0 gives 0.
- R10: While the operands stay constant and reset is low, `sum` stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset; clears the output register |
| a | input | N | First residue operand, in the range 0 to 2^N − 2 |
| b | input | N | Second residue operand, in the range 0 to 2^N − 2 |
| sum | output | N | (a + b) mod (2^N − 1), with a single zero |

## Verification
The main corner is the tie case a + b = 2^N − 1. Here the raw sum is all ones and there is no carry out. A design that ignored the all-propagate term would return the all-ones pattern, which is a second zero. Every such pair is driven at both widths. Carry-out sums, up to the largest pair 2^N − 2 plus 2^N − 2, catch an increment that drops its carry or flips the wrong bits, which shows up as an off-by-one result or a result larger by a power of two. Both topologies run side by side on the same operands, so a misrouted cell in either tree shows up as a mismatch on a few bit positions. Exhaustive 4-bit pairs and random 8-bit pairs cover the rest.

// File: rtl/mma_pkg.sv
package mma_pkg;

  typedef enum logic {
    TOPO_KS = 1'b0,
    TOPO_BK = 1'b1
  } topo_e;

  function automatic int tree_levels(input int width);
    return (width > 1) ? $clog2(width) : 1;
  endfunction

  function automatic int tree_stages(input int width, input topo_e topo);
    return (topo == TOPO_KS) ? tree_levels(width) : 2 * tree_levels(width) - 1;
  endfunction

endpackage

// File: rtl/mma_pg_pre.sv
module mma_pg_pre #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] p,
  output logic [N-1:0] g
);

  assign p = a ^ b;
  assign g = a & b;

endmodule

// File: rtl/mma_prefix_tree.sv
module mma_prefix_tree
  import mma_pkg::*;
#(
  parameter int    N    = 8,
  parameter topo_e TOPO = TOPO_KS
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  output logic [N-1:0] gpre,   // group generate over bits 0..i
  output logic         p_all   // group propagate over every bit
);

  localparam int L  = tree_levels(N);
  localparam int ST = tree_stages(N, TOPO);

  logic [ST:0][N-1:0] gs;
  logic [ST:0][N-1:0] ps;

  assign gs[0] = g;
  assign ps[0] = p;

  for (genvar s = 0; s < ST; s++) begin : g_stage
    localparam bit UP = (TOPO == TOPO_KS) || (s < L);
    localparam int K  = (TOPO == TOPO_KS) ? s : (UP ? s : 2 * L - 2 - s);
    localparam int D  = 1 << K;
    for (genvar i = 0; i < N; i++) begin : g_bit
      localparam bit ACT = (TOPO == TOPO_KS) ? (i >= D) :
                           (UP ? (((i + 1) % (2 * D)) == 0)
                               : ((((i + 1) % (2 * D)) == D) && (i >= 2 * D)));
      if (ACT) begin : g_cell
        assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][i-D]);
        assign ps[s+1][i] = ps[s][i] & ps[s][i-D];
      end else begin : g_pass
        assign gs[s+1][i] = gs[s][i];
        assign ps[s+1][i] = ps[s][i];
      end
    end
  end

  assign gpre  = gs[ST];
  assign p_all = &ps[ST];

endmodule

// File: rtl/mma_excess_one.sv
module mma_excess_one #(
  parameter int N = 8
) (
  input  logic [N-1:0] raw,
  input  logic         fix,
  output logic [N-1:0] res
);

  logic [N-1:0] flip;

  assign flip[0] = fix;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign flip[i] = flip[i-1] & raw[i-1];
  end

  assign res = raw ^ flip;

endmodule

// File: rtl/mod_mersenne_adder.sv
module mod_mersenne_adder
  import mma_pkg::*;
#(
  parameter int    N       = 8,
  parameter topo_e TOPO    = TOPO_KS,
  parameter bit    OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum
);

  logic [N-1:0] p, g, gpre, raw, res;
  logic         p_all, fix;

  mma_pg_pre #(.N(N)) u_pre (
    .a (a),
    .b (b),
    .p (p),
    .g (g)
  );

  mma_prefix_tree #(.N(N), .TOPO(TOPO)) u_tree (
    .p     (p),
    .g     (g),
    .gpre  (gpre),
    .p_all (p_all)
  );

  assign raw[0] = p[0];
  for (genvar i = 1; i < N; i++) begin : g_sum
    assign raw[i] = p[i] ^ gpre[i-1];
  end

  // correct when carry out is set or the whole word propagates
  assign fix = gpre[N-1] | p_all;

  mma_excess_one #(.N(N)) u_inc (
    .raw (raw),
    .fix (fix),
    .res (res)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) sum <= '0;
      else     sum <= res;
    end
  end else begin : g_comb
    assign sum = res;
  end

endmodule

// File: rtl/mma_checker.sv
module mma_checker #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic [N-1:0] sum
);

  localparam logic [N:0] MOD = {1'b0, {N{1'b1}}};

  logic [N:0] wide;
  logic       rst_q;

  assign wide = {1'b0, a} + {1'b0, b};

  always_ff @(posedge clk) rst_q <= rst;

  if (OUT_REG) begin : g_chk
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      rst_q |-> (sum == '0));  // R1

    AST_MOD_RESULT: assert property (@(posedge clk) disable iff (rst)
      (!rst_q && ($past(a) < MOD[N-1:0]) && ($past(b) < MOD[N-1:0]))
        |-> ({1'b0, sum} == ($past(wide) % MOD)));  // R2

    AST_TIE_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (wide == MOD) |=> (sum == '0));  // R3

    AST_NO_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
      sum != {N{1'b1}});  // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (!rst_q && $stable(a) && $stable(b)) |=> $stable(sum));  // R10
  end

endmodule

bind mod_mersenne_adder mma_checker #(.N(N), .OUT_REG(OUT_REG)) u_mma_chk (
  .clk (clk),
  .rst (rst),
  .a   (a),
  .b   (b),
  .sum (sum)
);

// File: tb/test_mod_mersenne_adder.sv
module test_mod_mersenne_adder;
  import mma_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a8 = '0, b8 = '0;
  logic [3:0] a4 = '0, b4 = '0;
  logic [7:0] s8ks, s8bk;
  logic [3:0] s4ks, s4bk;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mod_mersenne_adder #(.N(8), .TOPO(TOPO_KS)) i_mod_mersenne_adder (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .sum(s8ks));
  mod_mersenne_adder #(.N(8), .TOPO(TOPO_BK)) i_w8bk (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .sum(s8bk));
  mod_mersenne_adder #(.N(4), .TOPO(TOPO_KS)) i_w4ks (
    .clk(clk), .rst(rst), .a(a4), .b(b4), .sum(s4ks));
  mod_mersenne_adder #(.N(4), .TOPO(TOPO_BK)) i_w4bk (
    .clk(clk), .rst(rst), .a(a4), .b(b4), .sum(s4bk));

  function automatic int ref_mod(input int x, input int y, input int n);
    return (x + y) % ((1 << n) - 1);
  endfunction

  function automatic string case_tag(input int x, input int y, input int n);
    if (x + y == (1 << n) - 1) return "R3";
    if (x + y >= (1 << n))     return "R4";
    return "R5";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, result registered at the next rising edge,
  // sampled at the following falling edge
  task automatic step(input int x8, input int y8, input int x4, input int y4);
    @(negedge clk);
    a8 = 8'(x8); b8 = 8'(y8);
    a4 = 4'(x4); b4 = 4'(y4);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    a8 = 8'd100; b8 = 8'd77; a4 = 4'd9; b4 = 4'd3;
    repeat (3) @(negedge clk);
    chk("R1 w8 ks", int'(s8ks), 0);
    chk("R1 w8 bk", int'(s8bk), 0);
    chk("R1 w4 ks", int'(s4ks), 0);
    chk("R1 w4 bk", int'(s4bk), 0);
    rst = 1'b0;
  endtask

  task automatic t_exhaust4;
    for (int x = 0; x < 15; x++) begin
      for (int y = 0; y < 15; y++) begin
        step(0, 0, x, y);
        chk({"R2 ", case_tag(x, y, 4), " w4 ks"}, int'(s4ks), ref_mod(x, y, 4));
        chk({"R8 ", case_tag(x, y, 4), " w4 bk"}, int'(s4bk), ref_mod(x, y, 4));
        if (s4ks == 4'hF) chk("R6 w4", int'(s4ks), ref_mod(x, y, 4));
      end
    end
  endtask

  task automatic t_tie8;
    for (int x = 1; x < 255; x++) begin
      step(x, 255 - x, 0, 0);
      chk("R3 tie w8 ks", int'(s8ks), 0);
      chk("R3 tie w8 bk", int'(s8bk), 0);
    end
  endtask

  task automatic t_rand8;
    for (int k = 0; k < 400; k++) begin
      int x, y;
      x = int'($urandom % 255);
      y = int'($urandom % 255);
      step(x, y, 0, 0);
      chk({"R2 ", case_tag(x, y, 8), " w8 ks"}, int'(s8ks), ref_mod(x, y, 8));
      chk({"R8 ", case_tag(x, y, 8), " w8 bk"}, int'(s8bk), ref_mod(x, y, 8));
      chk("R6 w8", int'(s8ks == 8'hFF), 0);
    end
  endtask

  task automatic t_extremes;
    step(254, 254, 14, 14);
    chk("R4 max w8 ks", int'(s8ks), 253);
    chk("R4 max w8 bk", int'(s8bk), 253);
    chk("R4 max w4 ks", int'(s4ks), 13);
    chk("R4 max w4 bk", int'(s4bk), 13);
    step(128, 128, 8, 8);
    chk("R4 exact carry w8", int'(s8ks), 1);
    chk("R4 exact carry w4", int'(s4bk), 1);
    step(127, 127, 7, 7);
    chk("R5 below tie w8", int'(s8bk), 254);
    chk("R5 below tie w4", int'(s4ks), 14);
  endtask

  task automatic t_zero;
    step(0, 0, 0, 0);
    chk("R9 zero w8", int'(s8ks), 0);
    chk("R9 zero w4", int'(s4bk), 0);
    for (int x = 1; x < 255; x += 37) begin
      step(x, 0, x % 15, 0);
      chk("R9 identity w8 ks", int'(s8ks), x);
      chk("R9 identity w8 bk", int'(s8bk), x);
      chk("R9 identity w4", int'(s4ks), x % 15);
    end
  endtask

  task automatic t_commute;
    for (int k = 0; k < 20; k++) begin
      int x, y;
      logic [7:0] first8;
      logic [3:0] first4;
      x = int'($urandom % 255);
      y = int'($urandom % 255);
      step(x, y, x % 15, y % 15);
      first8 = s8ks;
      first4 = s4bk;
      step(y, x, y % 15, x % 15);
      chk("R7 swap w8", int'(s8ks), int'(first8));
      chk("R7 swap w4", int'(s4bk), int'(first4));
    end
  endtask

  task automatic t_hold;
    step(200, 99, 11, 6);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 hold w8", int'(s8ks), ref_mod(200, 99, 8));
      chk("R10 hold w4", int'(s4bk), ref_mod(11, 6, 4));
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    t_reset();
    t_exhaust4();
    t_tie8();
    t_extremes();
    t_rand8();
    t_zero();
    t_commute();
    t_hold();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

endmodule